// File: doc/BRIEF.md
# Latency-Counter Wakeup Scheduler

This block is the scheduling core of an out-of-order issue queue. It holds a small table of waiting instructions, one row per slot. Each row keeps a bit for every physical register that the instruction reads. A separate bank of per-register count-down timers tracks when each result will exist. When a row's instruction issues, the timer of its destination register starts, and the register's availability column rises after the stored latency has elapsed. The functional units never send a result tag back. Every cycle the block works out which rows are ready and grants the oldest of them, up to the issue width.

Issued rows are not freed. They stay in the table but are hidden from selection, so that a latency misprediction can be recovered by the surrounding logic. That logic can drop availability columns, make hidden rows visible again, force columns available, suppress all grants for one cycle, and free rows that no longer need to be kept.

Top module: `lc_wakeup_sched`

## Requirements
- R1: After reset no row is occupied, no grant is raised, every availability column reads 1, `ins_ok` is 1 and `ins_row` is 0.
- R2: An insert is written into the lowest-numbered free row, which `ins_row` shows in the insert cycle. When every row is occupied `ins_ok` is 0, and an insert offered then is ignored: its destination column is left unchanged.
- R3: A row can be granted only when every column it reads is 1, and never in the cycle in which it is inserted.
- R4: Inserting an instruction clears its destination column and stores its latency L (1 to 15; 0 acts as 1). A consumer of that register can be granted exactly L cycles after the cycle in which the producer was granted.
- R5: At most ISSUE_W rows are granted per cycle (`iss_grant` bit i means row i). The granted rows are the oldest ready rows by insertion order, not by row index.
- R6: A granted row stays occupied and is not granted again until `row_reveal` for it is pulsed. A revealed row competes again, and its re-issue restarts its destination timer with the stored latency.
- R7: While `mp_stall` is 1 nothing is granted, and no row is hidden and no timer is started in that cycle.
- R8: `col_clear` bit p sets column p to 0 at the next edge and cancels a running timer for p. This takes priority over a timer expiring at the same edge.
- R9: `col_set` bit p sets column p to 1 at the next edge.
- R10: `row_remove` bit i frees row i, and the row can be reused from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_src | input | N_PREG | Source register mask of the new instruction |
| ins_dst | input | PREG_W | Destination register of the new instruction |
| ins_lat | input | LAT_W | Execution latency of the new instruction |
| ins_ok | output | 1 | At least one row is free |
| ins_row | output | ROW_W | Row an insert this cycle would occupy |
| mp_stall | input | 1 | Misprediction cycle: suppress all grants |
| iss_grant | output | N_ENT | Rows granted this cycle |
| col_clear | input | N_PREG | Columns to mark unavailable |
| col_set | input | N_PREG | Columns to mark available |
| col_avail | output | N_PREG | Current availability of each register |
| row_reveal | input | N_ENT | Hidden rows to make selectable again |
| row_remove | input | N_ENT | Rows to free |

## Verification
The bench goes after the exact latency distance between a producer's grant and its consumer's grant. An off-by-one in the timer would move that grant a cycle early, which is a silent data hazard, or a cycle late. It builds a case in which the oldest rows sit at high indices, so that a select that sorts by index instead of by age grants the wrong four rows. It drives a column clear on the very edge at which a timer expires: a design that lets the expiry win would wake the consumer with stale data. It also checks that a stalled cycle neither hides the selected row nor starts its timer, and that an insert offered to a full table does not clear its destination column.

// File: rtl/lc_wakeup_sched.sv
module lc_wakeup_sched #(
  parameter int N_ENT   = 20,
  parameter int N_PREG  = 64,
  parameter int LAT_W   = 4,
  parameter int ISSUE_W = 4,
  parameter int AGE_W   = 8,
  localparam int ROW_W  = $clog2(N_ENT),
  localparam int PREG_W = $clog2(N_PREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [N_PREG-1:0] ins_src,
  input  logic [PREG_W-1:0] ins_dst,
  input  logic [LAT_W-1:0]  ins_lat,
  output logic              ins_ok,
  output logic [ROW_W-1:0]  ins_row,
  input  logic              mp_stall,
  output logic [N_ENT-1:0]  iss_grant,
  input  logic [N_PREG-1:0] col_clear,
  input  logic [N_PREG-1:0] col_set,
  output logic [N_PREG-1:0] col_avail,
  input  logic [N_ENT-1:0]  row_reveal,
  input  logic [N_ENT-1:0]  row_remove
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [N_ENT-1:0]  ent_v, hide;
  logic [N_PREG-1:0] src_q [N_ENT];
  logic [PREG_W-1:0] dst_q [N_ENT];
  logic [AGE_W-1:0]  age_q [N_ENT];

  logic [N_PREG-1:0] avail_q, armed;
  logic [LAT_W-1:0]  cnt_q [N_PREG];
  logic [LAT_W-1:0]  lat_q [N_PREG];

  logic [N_ENT-1:0]  ready, pool;
  logic [N_PREG-1:0] arm, ld;
  logic              do_ins, found;
  int                bi;

  assign col_avail = avail_q;
  assign ins_ok    = ~&ent_v;
  assign do_ins    = ins_valid && ins_ok;

  always_comb begin
    ins_row = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!ent_v[i]) ins_row = ROW_W'(i);
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_ready
    assign ready[i] = ent_v[i] && !hide[i] && ~|(src_q[i] & ~avail_q);
  end

  always_comb begin
    iss_grant = '0;
    pool      = mp_stall ? '0 : ready;
    found     = 1'b0;
    bi        = 0;
    for (int k = 0; k < ISSUE_W; k++) begin
      found = 1'b0;
      bi    = 0;
      for (int i = 0; i < N_ENT; i++)
        if (pool[i] && (!found || age_q[i] > age_q[bi])) begin
          found = 1'b1;
          bi    = i;
        end
      if (found) begin
        iss_grant[bi] = 1'b1;
        pool[bi]      = 1'b0;
      end
    end
  end

  always_comb begin
    arm = '0;
    ld  = '0;
    for (int p = 0; p < N_PREG; p++) begin
      ld[p] = do_ins && (ins_dst == PREG_W'(p));
      for (int i = 0; i < N_ENT; i++)
        if (iss_grant[i] && dst_q[i] == PREG_W'(p)) arm[p] = 1'b1;
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[i] <= 1'b0;
        hide[i]  <= 1'b0;
        age_q[i] <= '0;
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end else if (row_remove[i]) begin
        ent_v[i] <= 1'b0;
        hide[i]  <= 1'b0;
      end else if (do_ins && ins_row == ROW_W'(i)) begin
        ent_v[i] <= 1'b1;
        hide[i]  <= 1'b0;
        age_q[i] <= '0;
        src_q[i] <= ins_src;
        dst_q[i] <= ins_dst;
      end else begin
        if (row_reveal[i])     hide[i] <= 1'b0;
        else if (iss_grant[i]) hide[i] <= 1'b1;
        if (do_ins && ent_v[i] && age_q[i] != AGE_MAX)
          age_q[i] <= age_q[i] + 1'b1;
      end
    end

    assert_hide_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant[i] && !row_reveal[i] && !row_remove[i] |=> !iss_grant[i]);
  end

  for (genvar p = 0; p < N_PREG; p++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        avail_q[p] <= 1'b1;
        armed[p]   <= 1'b0;
        cnt_q[p]   <= '0;
        lat_q[p]   <= '0;
      end else begin
        if (ld[p]) lat_q[p] <= ins_lat;
        if (col_clear[p] || ld[p]) begin
          avail_q[p] <= 1'b0;
          armed[p]   <= 1'b0;
        end else if (arm[p]) begin
          if (lat_q[p] <= LAT_W'(1)) begin
            avail_q[p] <= 1'b1;
            armed[p]   <= 1'b0;
          end else begin
            cnt_q[p] <= lat_q[p] - 1'b1;
            armed[p] <= 1'b1;
          end
        end else if (col_set[p]) begin
          avail_q[p] <= 1'b1;
          armed[p]   <= 1'b0;
        end else if (armed[p]) begin
          if (cnt_q[p] <= LAT_W'(1)) begin
            avail_q[p] <= 1'b1;
            armed[p]   <= 1'b0;
          end else begin
            cnt_q[p] <= cnt_q[p] - 1'b1;
          end
        end
      end
    end

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      col_clear[p] |=> !col_avail[p]);
  end

  assert_grant_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_grant) <= ISSUE_W);

  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mp_stall |-> iss_grant == '0);

  assert_ins_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ok |=> !ins_ok || ins_row != $past(ins_row));

endmodule

// File: tb/tb_lc_wakeup_sched.sv
module tb_lc_wakeup_sched;
  localparam int N_ENT = 20, N_PREG = 64, LAT_W = 4;
  localparam int ROW_W = $clog2(N_ENT), PREG_W = $clog2(N_PREG);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, mp_stall = 1'b0;
  logic [N_PREG-1:0] ins_src = '0, col_clear = '0, col_set = '0, col_avail;
  logic [PREG_W-1:0] ins_dst = '0;
  logic [LAT_W-1:0]  ins_lat = '0;
  logic              ins_ok;
  logic [ROW_W-1:0]  ins_row;
  logic [N_ENT-1:0]  iss_grant, row_reveal = '0, row_remove = '0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lc_wakeup_sched dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    ins_valid = 0; mp_stall = 0; col_clear = '0; col_set = '0;
    row_reveal = '0; row_remove = '0;
    #1;
  endtask

  task automatic ins(input logic [N_PREG-1:0] s, input int d, input int l);
    ins_valid = 1; ins_src = s; ins_dst = PREG_W'(d); ins_lat = LAT_W'(l); #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) cyc();
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(iss_grant == '0, "R1 grant", iss_grant, 0);
    chk(&col_avail, "R1 avail", col_avail, '1);
    chk(ins_ok && ins_row == 0, "R1 ins", {ins_ok, ins_row}, {1'b1, 5'd0});
  endtask

  task automatic t_latency();
    do_reset();
    cyc(); ins('0, 5, 3);
    chk(ins_row == 0, "R2 row", ins_row, 0);
    chk(iss_grant == '0, "R3 not in insert cycle", iss_grant, 0);
    cyc(); ins(64'd1 << 5, 6, 1);
    chk(iss_grant == 20'h1, "R3 producer grant", iss_grant, 1);
    chk(ins_row == 1, "R2 row", ins_row, 1);
    chk(col_avail[5] == 0, "R4 dst cleared", col_avail[5], 0);
    cyc(); chk(iss_grant == '0, "R6 hidden R4 wait", iss_grant, 0);
    cyc(); chk(iss_grant == '0, "R4 wait", iss_grant, 0);
    cyc(); chk(iss_grant == 20'h2, "R4 consumer at L", iss_grant, 2);
    cyc(); ins('0, 7, 1);
    chk(iss_grant == '0, "R6 no regrant", iss_grant, 0);
    chk(ins_row == 2, "R6 rows kept", ins_row, 2);
    cyc(); chk(iss_grant == 20'h4, "R3 new row", iss_grant, 4);
  endtask

  task automatic t_oldest();
    do_reset();
    cyc(); col_clear = 64'd1 << 11; #1;
    cyc(); ins(64'd1 << 11, 10, 1);
    chk(ins_row == 0, "R2 row", ins_row, 0);
    for (int k = 1; k <= 6; k++) begin
      cyc(); ins(64'd1 << 10, 20 + k, 1);
      chk(ins_row == ROW_W'(k) && iss_grant == '0, "R3 blocked", {iss_grant, ins_row}, k);
    end
    cyc(); row_remove = 20'h6; #1;
    cyc(); ins(64'd1 << 10, 30, 1);
    chk(ins_row == 1, "R10 reuse", ins_row, 1);
    cyc(); ins(64'd1 << 10, 31, 1);
    chk(ins_row == 2, "R10 reuse", ins_row, 2);
    cyc(); col_set = 64'd1 << 11; #1;
    chk(iss_grant == '0, "R9 before set", iss_grant, 0);
    cyc(); chk(iss_grant == 20'h1, "R9 set wakes", iss_grant, 1);
    cyc(); chk(iss_grant == 20'h78, "R5 oldest four", iss_grant, 20'h78);
    cyc(); chk(iss_grant == 20'h06, "R5 remainder", iss_grant, 20'h06);
  endtask

  task automatic t_stall();
    do_reset();
    cyc(); ins('0, 5, 1);
    cyc(); mp_stall = 1; #1;
    chk(iss_grant == '0, "R7 stall", iss_grant, 0);
    cyc(); chk(iss_grant == 20'h1, "R7 not hidden", iss_grant, 1);
    chk(col_avail[5] == 0, "R7 no timer", col_avail[5], 0);
    cyc(); chk(col_avail[5] == 1, "R4 lat1", col_avail[5], 1);
    chk(iss_grant == '0, "R6 hidden", iss_grant, 0);
  endtask

  task automatic t_clear();
    do_reset();
    cyc(); ins('0, 5, 2);
    cyc(); ins(64'd1 << 5, 6, 1);
    chk(iss_grant == 20'h1, "R3 grant A", iss_grant, 1);
    cyc(); col_clear = 64'd1 << 5; #1;
    cyc(); chk(col_avail[5] == 0 && iss_grant == '0, "R8 clear beats expiry", {col_avail[5], iss_grant}, 0);
    cyc(); chk(col_avail[5] == 0, "R8 timer cancelled", col_avail[5], 0);
    row_reveal = 20'h1; #1;
    cyc(); chk(iss_grant == 20'h1, "R6 reveal", iss_grant, 1);
    cyc(); chk(iss_grant == '0, "R6 rearm wait", iss_grant, 0);
    cyc(); chk(iss_grant == 20'h2, "R6 rearm L", iss_grant, 2);
  endtask

  task automatic t_full();
    do_reset();
    cyc(); col_clear = 64'd1 << 11; #1;
    for (int k = 0; k < N_ENT; k++) begin
      cyc(); ins(64'd1 << 11, 20 + k, 1);
      if (k == N_ENT - 1) chk(ins_row == ROW_W'(k), "R2 last row", ins_row, k);
    end
    cyc(); chk(ins_ok == 0, "R2 full", ins_ok, 0);
    ins('0, 45, 3);
    cyc(); chk(col_avail[45] == 1, "R2 ignored", col_avail[45], 1);
    chk(iss_grant == '0, "R3 blocked", iss_grant, 0);
    row_remove = 20'h80; #1;
    cyc(); chk(ins_ok && ins_row == 7, "R10 freed", {ins_ok, ins_row}, {1'b1, 5'd7});
  endtask

  initial begin
    t_reset();
    t_latency();
    t_oldest();
    t_stall();
    t_clear();
    t_full();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule